// File: doc/BRIEF.md
# Binary-Tree Capacitor Scrambler for SAR Conversion

This block decides, for every bit decision of a successive-approximation conversion, which of two equal halves of that bit's unit-capacitor group is switched: the left half (choice 0) or the right half (choice 1). The choice for each step comes from a pseudo-random bit. The choices are gathered, most significant step first, into a path code. Each step's choice fixes one more bit of that code, so the code walks down a binary tree and ends on one leaf per conversion. Because fresh random bits are drawn for every conversion, element mismatch turns into noise and is not a fixed pattern.

The sequencer of the converter pulses a conversion start, then strobes each step with its index (0 is the MSB decision). One cycle after an accepted strobe, the block presents the side to switch and the updated path code. A scramble-enable input forces every choice to the left half, so that a fixed assignment can be compared with the scrambled one. Driving the capacitor switches is left to the logic that consumes these outputs.

Top module: `bdem_selector`

## Requirements
- R1: After a synchronous reset, `dem_code` is all zeros and `sel_side` and `sel_valid` are low. The random source restarts from its seed value 16'hACE1.
- R2: A strobe with `step_idx` = k (0 ≤ k < RES_BITS, 0 being the MSB decision) is accepted. On the next clock edge, `sel_side` shows the chosen side (0 = left, 1 = right), `dem_code` bit RES_BITS-1-k takes that same value, and `sel_valid` is high for exactly one cycle.
- R3: The random bit for an accepted strobe is bit 15 of a 16-bit shift register, read before that register advances. On each advance the register shifts toward the MSB, and bit 0 takes the XOR of bits 15, 13, 12 and 10 (a maximal-length sequence). The register advances once per accepted strobe and at no other time.
- R4: `conv_start` clears `dem_code` and `sel_side` on the next edge. A strobe in the same cycle is ignored: no code update, no valid pulse and no advance of the random source.
- R5: While `dem_en` is low, an accepted strobe yields side 0 in both `sel_side` and the code bit. The random source still advances.
- R6: A strobe with `step_idx` ≥ RES_BITS is ignored: `dem_code` is unchanged, `sel_valid` stays low and the random source does not advance.
- R7: Code bits that no strobe addresses keep their value. A repeated strobe of the same step overwrites that step's bit with a new random choice.
- R8: Over many scrambled conversions, the fraction of right-half choices at every tree level lies between 40 % and 60 %.
- R9: Paths change from conversion to conversion. Over 64 scrambled 6-step conversions, at least 24 distinct leaf codes occur.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| conv_start | input | 1 | Start of a conversion; clears the path code |
| step_strobe | input | 1 | One-cycle pulse per SAR bit decision |
| step_idx | input | $clog2(RES_BITS) | Index of the decision, 0 = MSB |
| dem_en | input | 1 | Scrambling enabled when high; all choices left when low |
| sel_side | output | 1 | Half to switch for the latest step (0 left, 1 right) |
| sel_valid | output | 1 | High for one cycle after an accepted step |
| dem_code | output | RES_BITS | Accumulated tree path, MSB-step choice in the top bit |

## Verification
The random source is not visible at the ports. This makes the cases where it must not move the hardest to observe: a strobe coinciding with a conversion start, and a strobe with an index beyond the resolution. The bench places such a strobe and then an ordinary accepted step. It compares that step's choice with a model that has not advanced, so a stray advance shows up as a wrong side bit. The statistical requirements are reached by running hundreds of back-to-back conversions and counting right-half choices per level and distinct leaves.

// File: rtl/bdem_pkg.sv
package bdem_pkg;
  typedef struct packed {
    logic take;  // accepted step this cycle
    logic wipe;  // conversion start this cycle
  } bdem_ctl_t;

  localparam int unsigned LFSR_W_DEF = 16;
  localparam logic [15:0] TAPS_DEF   = 16'hB400; // bits 15,13,12,10
  localparam logic [15:0] SEED_DEF   = 16'hACE1;
endpackage

// File: rtl/bdem_lfsr.sv
module bdem_lfsr #(
  parameter int unsigned W        = 16,
  parameter logic [W-1:0] TAPS    = 16'hB400,
  parameter logic [W-1:0] SEED    = 16'hACE1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic         rnd,
  output logic [W-1:0] state
);
  logic         fb;
  logic [W-1:0] state_q;

  always_comb fb = ^(state_q & TAPS);

  always_ff @(posedge clk) begin
    if (rst)      state_q <= SEED;
    else if (adv) state_q <= {state_q[W-2:0], fb};
  end

  assign rnd   = state_q[W-1];
  assign state = state_q;
endmodule

// File: rtl/bdem_step_ctl.sv
module bdem_step_ctl
  import bdem_pkg::*;
#(
  parameter int unsigned RES_BITS = 6,
  localparam int unsigned IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic                conv_start,
  input  logic                step_strobe,
  input  logic [IDX_W-1:0]    step_idx,
  output bdem_ctl_t           ctl,
  output logic [RES_BITS-1:0] pos_oh
);
  localparam logic [IDX_W:0] RES_L = (IDX_W+1)'(RES_BITS);

  logic in_range;

  always_comb begin
    in_range = ({1'b0, step_idx} < RES_L);
    ctl.wipe = conv_start;
    ctl.take = step_strobe & ~conv_start & in_range;
  end

  // step 0 maps to the top code bit
  for (genvar k = 0; k < RES_BITS; k++) begin : g_pos
    assign pos_oh[RES_BITS-1-k] = (step_idx == IDX_W'(k));
  end
endmodule

// File: rtl/bdem_code_reg.sv
module bdem_code_reg #(
  parameter int unsigned RES_BITS = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wipe,
  input  logic                take,
  input  logic [RES_BITS-1:0] pos_oh,
  input  logic                bit_in,
  output logic [RES_BITS-1:0] code
);
  for (genvar i = 0; i < RES_BITS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst || wipe)          code[i] <= 1'b0;
      else if (take && pos_oh[i]) code[i] <= bit_in;
    end
  end
endmodule

// File: rtl/bdem_selector.sv
module bdem_selector
  import bdem_pkg::*;
#(
  parameter int unsigned RES_BITS = 6,
  parameter int unsigned LFSR_W   = LFSR_W_DEF,
  parameter logic [LFSR_W-1:0] LFSR_TAPS = TAPS_DEF,
  parameter logic [LFSR_W-1:0] LFSR_SEED = SEED_DEF,
  localparam int unsigned IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                conv_start,
  input  logic                step_strobe,
  input  logic [IDX_W-1:0]    step_idx,
  input  logic                dem_en,
  output logic                sel_side,
  output logic                sel_valid,
  output logic [RES_BITS-1:0] dem_code
);
  bdem_ctl_t           ctl;
  logic [RES_BITS-1:0] pos_oh;
  logic                rnd;
  logic [LFSR_W-1:0]   lfsr_q;
  logic                side_d;

  bdem_step_ctl #(.RES_BITS(RES_BITS)) u_ctl (
    .conv_start (conv_start),
    .step_strobe(step_strobe),
    .step_idx   (step_idx),
    .ctl        (ctl),
    .pos_oh     (pos_oh)
  );

  bdem_lfsr #(.W(LFSR_W), .TAPS(LFSR_TAPS), .SEED(LFSR_SEED)) u_lfsr (
    .clk  (clk),
    .rst  (rst),
    .adv  (ctl.take),
    .rnd  (rnd),
    .state(lfsr_q)
  );

  always_comb side_d = rnd & dem_en;

  bdem_code_reg #(.RES_BITS(RES_BITS)) u_code (
    .clk   (clk),
    .rst   (rst),
    .wipe  (ctl.wipe),
    .take  (ctl.take),
    .pos_oh(pos_oh),
    .bit_in(side_d),
    .code  (dem_code)
  );

  always_ff @(posedge clk) begin
    if (rst || ctl.wipe) begin
      sel_side  <= 1'b0;
      sel_valid <= 1'b0;
    end else begin
      sel_valid <= ctl.take;
      if (ctl.take) sel_side <= side_d;
    end
  end
endmodule

// File: rtl/bdem_selector_chk.sv
module bdem_selector_chk #(
  parameter int unsigned RES_BITS = 6,
  parameter int unsigned LFSR_W   = 16,
  localparam int unsigned IDX_W   = (RES_BITS > 1) ? $clog2(RES_BITS) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                conv_start,
  input logic                step_strobe,
  input logic [IDX_W-1:0]    step_idx,
  input logic                dem_en,
  input logic                sel_side,
  input logic                sel_valid,
  input logic [RES_BITS-1:0] dem_code,
  input logic [LFSR_W-1:0]   lfsr_state
);
  logic ok_idx;
  always_comb ok_idx = (int'(step_idx) < RES_BITS);

  assert_step_writes_R2: assert property (@(posedge clk) disable iff (rst)
    (step_strobe && !conv_start && ok_idx) |=>
      (sel_valid && dem_code[RES_BITS-1-int'($past(step_idx))] == sel_side));

  assert_seed_nonzero_R3: assert property (@(posedge clk) disable iff (rst)
    lfsr_state != '0);

  assert_start_clears_R4: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> (dem_code == '0 && !sel_valid && !sel_side));

  assert_disabled_left_R5: assert property (@(posedge clk) disable iff (rst)
    (step_strobe && !conv_start && ok_idx && !dem_en) |=> !sel_side);

  assert_bad_index_ignored_R6: assert property (@(posedge clk) disable iff (rst)
    (step_strobe && !conv_start && !ok_idx) |=> ($stable(dem_code) && !sel_valid));

  assert_idle_holds_R7: assert property (@(posedge clk) disable iff (rst)
    (!step_strobe && !conv_start) |=> ($stable(dem_code) && !sel_valid));
endmodule

bind bdem_selector bdem_selector_chk #(.RES_BITS(RES_BITS), .LFSR_W(LFSR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .conv_start (conv_start),
  .step_strobe(step_strobe),
  .step_idx   (step_idx),
  .dem_en     (dem_en),
  .sel_side   (sel_side),
  .sel_valid  (sel_valid),
  .dem_code   (dem_code),
  .lfsr_state (lfsr_q)
);

// File: tb/bdem_selector_bench.sv
module bdem_selector_bench;
  localparam int RES = 6;
  localparam int IW  = $clog2(RES);

  logic clk = 1'b0;
  logic rst, conv_start, step_strobe, dem_en;
  logic [IW-1:0]  step_idx;
  logic           sel_side, sel_valid;
  logic [RES-1:0] dem_code;

  always #5 clk = ~clk;

  bdem_selector #(.RES_BITS(RES)) u_bdem_selector (
    .clk(clk), .rst(rst), .conv_start(conv_start), .step_strobe(step_strobe),
    .step_idx(step_idx), .dem_en(dem_en), .sel_side(sel_side),
    .sel_valid(sel_valid), .dem_code(dem_code)
  );

  int n_chk = 0, n_err = 0;
  bit reported = 0;
  logic [15:0]    m_lfsr;
  logic [RES-1:0] m_code;
  logic           m_side;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    end
  endtask

  // model of R3 source and R2/R5 writes
  function automatic void m_accept(input int idx, input bit en);
    bit b = m_lfsr[15];
    m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
    m_side = b & en;
    m_code[RES-1-idx] = m_side;
  endfunction

  // one-cycle pulse driven at negedge; outputs sampled at following negedge
  task automatic pulse(input bit st, input bit sb, input int idx);
    @(negedge clk);
    conv_start = st; step_strobe = sb; step_idx = IW'(idx);
    @(negedge clk);
    conv_start = 0; step_strobe = 0;
  endtask

  task automatic start_conv();
    pulse(1, 0, 0);
    m_code = '0; m_side = 0;
  endtask

  task automatic good_step(input int idx, input string req);
    pulse(0, 1, idx);
    m_accept(idx, dem_en);
    check(sel_side == m_side, {req, " side"}, sel_side, m_side);
    check(dem_code == m_code, {req, " code"}, dem_code, m_code);
    check(sel_valid == 1'b1, {req, " valid"}, sel_valid, 1);
  endtask

  task automatic t_reset();
    rst = 1; conv_start = 0; step_strobe = 0; step_idx = '0; dem_en = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_lfsr = 16'hACE1; m_code = '0; m_side = 0;
    check(dem_code == '0, "R1 code", dem_code, 0);
    check(!sel_side && !sel_valid, "R1 side/valid", {sel_side, sel_valid}, 0);
  endtask

  task automatic t_basic();
    start_conv();
    for (int k = 0; k < RES; k++) good_step(k, "R2 R3");
    @(negedge clk);
    check(sel_valid == 1'b0, "R2 valid one cycle", sel_valid, 0);
    check(dem_code == m_code, "R7 hold idle", dem_code, m_code);
  endtask

  task automatic t_partial_and_restrobe();
    start_conv();
    check(dem_code == '0, "R4 clear", dem_code, 0);
    good_step(0, "R7 first");
    good_step(3, "R7 skip");
    good_step(3, "R7 restrobe");
    good_step(0, "R7 restrobe msb");
  endtask

  task automatic t_start_priority();
    start_conv();
    good_step(0, "R4 pre");
    good_step(1, "R4 pre");
    pulse(1, 1, 2);
    m_code = '0; m_side = 0;
    check(dem_code == '0, "R4 clear with strobe", dem_code, 0);
    check(!sel_valid && !sel_side, "R4 no valid", {sel_side, sel_valid}, 0);
    good_step(0, "R4 no advance");
    good_step(1, "R4 no advance");
  endtask

  task automatic t_disabled();
    start_conv();
    dem_en = 0;
    for (int k = 0; k < RES; k++) good_step(k, "R5");
    check(dem_code == '0, "R5 all left", dem_code, 0);
    dem_en = 1;
    good_step(2, "R5 still advanced");
  endtask

  task automatic t_bad_index();
    start_conv();
    good_step(0, "R6 pre");
    pulse(0, 1, 6);
    check(dem_code == m_code, "R6 code kept", dem_code, m_code);
    check(!sel_valid, "R6 no valid", sel_valid, 0);
    pulse(0, 1, 7);
    check(dem_code == m_code, "R6 code kept 7", dem_code, m_code);
    good_step(1, "R6 no advance");
  endtask

  task automatic t_stats();
    int ones[RES];
    bit seen[64];
    int distinct = 0;
    int n = 500;
    foreach (ones[i]) ones[i] = 0;
    foreach (seen[i]) seen[i] = 0;
    dem_en = 1;
    for (int c = 0; c < n; c++) begin
      start_conv();
      for (int k = 0; k < RES; k++) begin
        pulse(0, 1, k);
        m_accept(k, 1);
        if (sel_side) ones[k]++;
      end
      if (dem_code != m_code) check(0, "R8 code track", dem_code, m_code);
      if (c < 64 && !seen[dem_code]) begin
        seen[dem_code] = 1;
        distinct++;
      end
    end
    for (int k = 0; k < RES; k++)
      check(ones[k] >= n*2/5 && ones[k] <= n*3/5, "R8 level balance", ones[k], n/2);
    check(distinct >= 24, "R9 distinct leaves", distinct, 24);
  endtask

  initial begin
    t_reset();
    t_basic();
    t_partial_and_restrobe();
    t_start_priority();
    t_disabled();
    t_bad_index();
    t_stats();
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL R8 watchdog actual=running expected=done");
    report();
    $finish;
  end
endmodule